// File: doc/BRIEF.md
# Stream-to-Burst Packer with Region Boundary Cuts

This block sits between a packetised input stream of wide data words and a memory write path. It groups the incoming words into write bursts. Burst data leaves on one output stream toward the memory writer. A short record for each burst leaves on a separate side channel toward the address planner. That record gives the word count, whether the burst ends a packet, and whether it ends a destination region.

A burst closes on the first of three events: it reaches the build-time maximum length, the fixed-size destination region becomes full, or the input marks the last word of a packet. Packets are laid back to back inside a region with no padding. The write offset inside the current region is therefore carried from one packet to the next. The offset is counted in words (region bytes divided by the word width in bytes). It returns to zero when a burst that fills the region closes. Both outputs are registered, and the input is stalled whenever either output still holds an item that has not been taken.

Top module: `burst_packer`

## Requirements
- R1: After reset, neither output presents a valid item and the input is ready.
- R2: Every accepted input word appears exactly once on the data output, in order, with its payload unchanged, whatever the back-pressure on either output.
- R3: A burst that closes for neither a packet end nor a region end holds exactly MAX_BURST words; its record has length MAX_BURST with both the packet-end and region-end bits clear.
- R4: The input last flag closes the burst on that word; the record carries the packet-end bit set and the word count of that burst.
- R5: The word that fills the destination region (offset REGION_BYTES/(DATA_W/8) - 1) closes the burst with the region-end bit set, and the next word starts at region offset zero.
- R6: A new packet continues at the region offset where the previous packet ended, so region cuts fall at multiples of the region word count counted across packets.
- R7: A word that is both a packet end and a region end closes one burst whose record has both bits set; when it also completes a maximum-length burst, still only one record is produced.
- R8: The record of a burst becomes valid in the same cycle as the final data word of that burst, which is flagged by the data output's last bit.
- R9: While either output holds an item its receiver has not taken, the input is not ready, and the held item stays valid and unchanged.
- R10: Every record's word count is between 1 and MAX_BURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_data_i | input | DATA_W | Input stream word |
| s_last_i | input | 1 | Last word of a packet |
| s_valid_i | input | 1 | Input word valid |
| s_ready_o | output | 1 | Input word accepted when high with valid |
| w_data_o | output | DATA_W | Burst data word toward the writer |
| w_last_o | output | 1 | Final word of a burst |
| w_valid_o | output | 1 | Burst data valid |
| w_ready_i | input | 1 | Writer takes the data word |
| p_len_o | output | $clog2(MAX_BURST+1) | Word count of the burst |
| p_eop_o | output | 1 | Burst ends a packet |
| p_eor_o | output | 1 | Burst ends a destination region |
| p_valid_o | output | 1 | Burst record valid |
| p_ready_i | input | 1 | Planner takes the record |

## Verification
Three closing causes can fall on the same word: a packet end, the region filling, and the maximum length. A run is built with a 4-word maximum and a 10-word region, and packet lengths are chosen so that one packet's last word lands exactly on a region end. That word also completes a full burst. The scoreboard's reference model then expects exactly one record with both end bits set and length four. A second collision is between the two output channels: random, independent back-pressure on the writer and the planner is used to check that records stay aligned with the final data words, and that no word is lost or repeated while one channel stalls the other.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  // reasons a burst closes on the current word
  typedef struct packed {
    logic at_max;
    logic at_eor;
    logic at_eop;
  } cut_t;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bpk_cut_tracker.sv
module bpk_cut_tracker
  import bpk_pkg::*;
#(
  parameter int unsigned MAX_BURST    = 256,
  parameter int unsigned REGION_WORDS = 65536,
  localparam int unsigned LEN_W = $clog2(MAX_BURST + 1),
  localparam int unsigned OFF_W = width_of(REGION_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             last_i,
  output cut_t             cut_o,
  output logic             close_o,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic             hit_max;
  logic             hit_eor;

  generate
    if (MAX_BURST == 1) begin : g_single
      assign hit_max = 1'b1;
    end else begin : g_multi
      assign hit_max = (cnt_q == LEN_W'(MAX_BURST - 1));
    end
  endgenerate

  assign hit_eor = (off_q == OFF_W'(REGION_WORDS - 1));

  assign cut_o.at_max = hit_max;
  assign cut_o.at_eor = hit_eor;
  assign cut_o.at_eop = last_i;
  assign close_o      = hit_max | hit_eor | last_i;
  assign len_o        = cnt_q + LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      off_q <= '0;
    end else if (adv_i) begin
      cnt_q <= close_o ? '0 : cnt_q + LEN_W'(1);
      off_q <= hit_eor ? '0 : off_q + OFF_W'(1);
    end
  end
endmodule

// File: rtl/bpk_out_stage.sv
module bpk_out_stage #(
  parameter int unsigned DATA_W = 256,
  parameter int unsigned LEN_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_close_i,
  input  logic [LEN_W-1:0]  in_len_i,
  input  logic              in_eop_i,
  input  logic              in_eor_i,
  output logic [DATA_W-1:0] w_data_o,
  output logic              w_last_o,
  output logic              w_valid_o,
  input  logic              w_ready_i,
  output logic [LEN_W-1:0]  p_len_o,
  output logic              p_eop_o,
  output logic              p_eor_o,
  output logic              p_valid_o,
  input  logic              p_ready_i
);
  logic w_free, p_free, take;

  assign w_free     = !w_valid_o || w_ready_i;
  assign p_free     = !p_valid_o || p_ready_i;
  assign in_ready_o = w_free && p_free;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_valid_o <= 1'b0;
      w_data_o  <= '0;
      w_last_o  <= 1'b0;
    end else if (take) begin
      w_valid_o <= 1'b1;
      w_data_o  <= in_data_i;
      w_last_o  <= in_close_i;
    end else if (w_ready_i) begin
      w_valid_o <= 1'b0;
    end
  end

  // record is loaded on the same edge as the final data word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_valid_o <= 1'b0;
      p_len_o   <= '0;
      p_eop_o   <= 1'b0;
      p_eor_o   <= 1'b0;
    end else if (take && in_close_i) begin
      p_valid_o <= 1'b1;
      p_len_o   <= in_len_i;
      p_eop_o   <= in_eop_i;
      p_eor_o   <= in_eor_i;
    end else if (p_ready_i) begin
      p_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_packer.sv
module burst_packer
  import bpk_pkg::*;
#(
  parameter int unsigned DATA_W       = 256,
  parameter int unsigned MAX_BURST    = 256,
  parameter int unsigned REGION_BYTES = 2097152,
  localparam int unsigned LEN_W        = $clog2(MAX_BURST + 1),
  localparam int unsigned REGION_WORDS = REGION_BYTES / (DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] w_data_o,
  output logic              w_last_o,
  output logic              w_valid_o,
  input  logic              w_ready_i,
  output logic [LEN_W-1:0]  p_len_o,
  output logic              p_eop_o,
  output logic              p_eor_o,
  output logic              p_valid_o,
  input  logic              p_ready_i
);
  cut_t             cut;
  logic             close;
  logic [LEN_W-1:0] len;
  logic             adv;

  assign adv = s_valid_i && s_ready_o;

  bpk_cut_tracker #(
    .MAX_BURST   (MAX_BURST),
    .REGION_WORDS(REGION_WORDS)
  ) u_cut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .last_i (s_last_i),
    .cut_o  (cut),
    .close_o(close),
    .len_o  (len)
  );

  bpk_out_stage #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(s_valid_i),
    .in_ready_o(s_ready_o),
    .in_data_i (s_data_i),
    .in_close_i(close || cut.at_max),
    .in_len_i  (len),
    .in_eop_i  (cut.at_eop),
    .in_eor_i  (cut.at_eor),
    .w_data_o  (w_data_o),
    .w_last_o  (w_last_o),
    .w_valid_o (w_valid_o),
    .w_ready_i (w_ready_i),
    .p_len_o   (p_len_o),
    .p_eop_o   (p_eop_o),
    .p_eor_o   (p_eor_o),
    .p_valid_o (p_valid_o),
    .p_ready_i (p_ready_i)
  );
endmodule

// File: rtl/burst_packer_chk.sv
module burst_packer_chk #(
  parameter int unsigned DATA_W    = 256,
  parameter int unsigned MAX_BURST = 256,
  localparam int unsigned LEN_W = $clog2(MAX_BURST + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_last_i,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [DATA_W-1:0] w_data_o,
  input logic              w_last_o,
  input logic              w_valid_o,
  input logic              w_ready_i,
  input logic [LEN_W-1:0]  p_len_o,
  input logic              p_eop_o,
  input logic              p_eor_o,
  input logic              p_valid_o,
  input logic              p_ready_i
);
  // R9
  w_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && !w_ready_i) |=> (w_valid_o && $stable(w_data_o) && $stable(w_last_o)));

  // R9
  p_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_valid_o && !p_ready_i) |=> (p_valid_o && $stable(p_len_o) && $stable(p_eop_o) && $stable(p_eor_o)));

  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((w_valid_o && !w_ready_i) || (p_valid_o && !p_ready_i)) |-> !s_ready_o);

  // R4
  eop_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o && s_last_i) |=> (p_valid_o && p_eop_o && w_valid_o && w_last_o));

  // R10
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_valid_o |-> (p_len_o != '0 && p_len_o <= LEN_W'(MAX_BURST)));

  // R3
  full_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_valid_o && !p_eop_o && !p_eor_o) |-> (p_len_o == LEN_W'(MAX_BURST)));
endmodule

bind burst_packer burst_packer_chk #(
  .DATA_W   (DATA_W),
  .MAX_BURST(MAX_BURST)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .s_last_i (s_last_i),
  .s_valid_i(s_valid_i),
  .s_ready_o(s_ready_o),
  .w_data_o (w_data_o),
  .w_last_o (w_last_o),
  .w_valid_o(w_valid_o),
  .w_ready_i(w_ready_i),
  .p_len_o  (p_len_o),
  .p_eop_o  (p_eop_o),
  .p_eor_o  (p_eor_o),
  .p_valid_o(p_valid_o),
  .p_ready_i(p_ready_i)
);

// File: tb/tb_burst_packer.sv
module tb_burst_packer;
  localparam int unsigned DW    = 256;
  localparam int unsigned MAXB  = 4;
  localparam int unsigned RBYT  = 320;
  localparam int unsigned RW    = RBYT / (DW / 8);
  localparam int unsigned LW    = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] w_data;
  logic          w_last, w_valid;
  logic          w_ready = 1'b1;
  logic [LW-1:0] p_len;
  logic          p_eop, p_eor, p_valid;
  logic          p_ready = 1'b1;

  always #10 clk = ~clk;

  burst_packer #(.DATA_W(DW), .MAX_BURST(MAXB), .REGION_BYTES(RBYT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_data_i(s_data), .s_last_i(s_last), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .w_data_o(w_data), .w_last_o(w_last), .w_valid_o(w_valid), .w_ready_i(w_ready),
    .p_len_o(p_len), .p_eop_o(p_eop), .p_eor_o(p_eor), .p_valid_o(p_valid), .p_ready_i(p_ready)
  );

  int vec = 0;
  int bad = 0;
  logic [DW:0]   dq[$];
  logic [LW+1:0] pq[$];
  int  m_cnt = 0;
  int  m_off = 0;
  int  seq = 0;
  bit  bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;

  task automatic chk(input bit ok, input string msg);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  // driver: push expectations from the requirement model, then offer the word
  task automatic send_word(input bit last);
    logic [DW-1:0] d;
    bit hm, hr, cl;
    d  = {8{32'(seq) ^ 32'h5A00_0000}};
    seq++;
    hm = (m_cnt == MAXB - 1);
    hr = (m_off == RW - 1);
    cl = hm | hr | last;
    dq.push_back({cl, d});
    if (cl) pq.push_back({LW'(m_cnt + 1), last, hr});
    m_cnt = cl ? 0 : m_cnt + 1;
    m_off = hr ? 0 : m_off + 1;
    s_data  = d;
    s_last  = last;
    s_valid = 1'b1;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int gap_every);
    for (int i = 0; i < len; i++) begin
      send_word(i == len - 1);
      if (gap_every != 0 && (i % gap_every) == gap_every - 1) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  // back-pressure pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    w_ready = bp_en ? lfsr[0] : 1'b1;
    p_ready = bp_en ? (lfsr[3] | lfsr[7]) : 1'b1;
  end

  // monitor / scoreboard
  logic          pw_valid = 1'b0, pw_ready = 1'b0, pw_last = 1'b0;
  logic [DW-1:0] pw_data = '0;
  logic          pp_valid = 1'b0, pp_ready = 1'b0;
  logic [LW+1:0] pp_rec = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pw_valid && !pw_ready)  // R9
        chk(w_valid && w_data == pw_data && w_last == pw_last,
            $sformatf("R9 held data changed: valid %0b last %0b exp last %0b", w_valid, w_last, pw_last));
      if (pp_valid && !pp_ready)  // R9
        chk(p_valid && {p_len, p_eop, p_eor} == pp_rec,
            $sformatf("R9 held record changed: %h exp %h", {p_len, p_eop, p_eor}, pp_rec));
      if (((w_valid && !w_ready) || (p_valid && !p_ready)) && s_valid)  // R9
        chk(!s_ready, "R9 input ready while an output is held: act 1 exp 0");
      if (w_valid && w_last && (!pw_valid || pw_ready))  // R8
        chk(p_valid, "R8 final word presented without record: act 0 exp 1");
      if (w_valid && w_ready) begin  // R2 R3 R5 R6 R7
        if (dq.size() == 0) chk(1'b0, "R2 unexpected data word: act extra exp none");
        else begin
          logic [DW:0] e;
          e = dq.pop_front();
          chk({w_last, w_data} == e,
              $sformatf("R2 data/last: act %0b/%h exp %0b/%h", w_last, w_data[31:0], e[DW], e[31:0]));
        end
      end
      if (p_valid && p_ready) begin  // R3 R4 R5 R6 R7 R10
        if (pq.size() == 0) chk(1'b0, "R10 unexpected record: act extra exp none");
        else begin
          logic [LW+1:0] e;
          e = pq.pop_front();
          chk({p_len, p_eop, p_eor} == e,
              $sformatf("R3/R4/R5/R7 record len,eop,eor: act %0d,%0b,%0b exp %0d,%0b,%0b",
                        p_len, p_eop, p_eor, e[LW+1:2], e[1], e[0]));
        end
      end
    end
    pw_valid = w_valid; pw_ready = w_ready; pw_last = w_last; pw_data = w_data;
    pp_valid = p_valid; pp_ready = p_ready; pp_rec = {p_len, p_eop, p_eor};
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "watchdog expired: act running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1
    chk(!w_valid && !p_valid, $sformatf("R1 outputs valid in reset: act %0b%0b exp 00", w_valid, p_valid));
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready && !w_valid && !p_valid,
        $sformatf("R1 after reset ready/wv/pv: act %0b%0b%0b exp 100", s_ready, w_valid, p_valid));
    @(posedge clk); #1;
    // R4: short packet closes on its last word
    send_pkt(3, 0);
    // R3 R5 R6: packet crossing a region end; offset carried from previous packet
    send_pkt(9, 0);
    // R7: packet end, region end and full length on the same word
    send_pkt(8, 0);
    // R4: single-word packet
    send_pkt(1, 0);
    // R2 R9: random back-pressure on both outputs, idle gaps on input
    bp_en = 1'b1;
    send_pkt(25, 3);
    r = 16'h1D3B;
    for (int k = 0; k < 14; k++) begin
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      send_pkt(int'(r[4:0] % 23) + 1, (k % 2 == 0) ? 0 : 2);
    end
    bp_en = 1'b0;
    for (int t = 0; t < 200 && (dq.size() != 0 || pq.size() != 0); t++) @(negedge clk);
    // R2 R10: everything expected was delivered
    chk(dq.size() == 0 && pq.size() == 0,
        $sformatf("R2 leftover items: act %0d/%0d exp 0/0", dq.size(), pq.size()));
    @(negedge clk);
    chk(s_ready && !w_valid && !p_valid,
        $sformatf("R9 idle state ready/wv/pv: act %0b%0b%0b exp 100", s_ready, w_valid, p_valid));
    summary();
    $finish;
  end
endmodule